// File: doc/BRIEF.md
# Parallel Port Reverse-Channel Byte Receiver

This block is the host end of the reverse direction of an interlocked parallel-port channel. The peripheral offers a byte by pulling its strobe line (`periphClkIn`) low, with the 8-bit bus already settled. The host answers by raising its acknowledge line (`hostAck`). The peripheral then releases its strobe high. The host keeps the byte and drops the acknowledge to close the cycle. While no byte is on offer, the strobe sits high and the acknowledge sits low.

The strobe arrives asynchronously and passes through a flop synchroniser. The bus is sampled into a holding register once the synchronised strobe reads low. That byte is published to a one-entry output register with a valid flag only after the strobe has gone back high. The acknowledge is raised only when the output register is empty and the consumer asserts `outReady`, so a full host holds the peripheral off. If the strobe fails to return high within a set number of clocks after the acknowledge, the transfer is abandoned. The acknowledge drops, a sticky error flag is set, and the engine waits for the strobe to go high before it accepts anything new.

Top module: `ecpRevReceiver`

## Requirements
- R1: After reset `hostAck`, `outValid` and `timeoutErr` are all 0.
- R2: While `periphClkIn` stays high, `hostAck` stays 0 and no byte is published.
- R3: With the output register empty and `outReady` at 1, `hostAck` goes to 1 on the fourth rising clock edge after `periphClkIn` falls. This is two synchroniser stages, one capture cycle and one acknowledge cycle.
- R4: `hostAck` stays 0 while `outReady` is 0 or the output register holds an unconsumed byte, even if the strobe is low.
- R5: The byte is published on the third rising edge after `periphClkIn` rises. On that same edge `outValid` goes to 1 and `hostAck` returns to 0. Before that edge `outValid` stays 0.
- R6: A published byte stays valid and unchanged while `outReady` is 0. It is consumed, and `outValid` goes to 0, on the first edge where `outValid` and `outReady` are both 1.
- R7: If the strobe is still low `TIMEOUT_CYCLES` clocks after `hostAck` rises, `hostAck` goes to 0 and `timeoutErr` goes to 1. The flag stays 1 until reset, and the abandoned byte is never published.
- R8: After a timeout, `hostAck` stays 0 until `periphClkIn` has been seen high. Normal transfers then resume.
- R9: The published byte is the bus value present when the strobe fell. Bus changes after `hostAck` rises do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| periphClkIn | input | 1 | Peripheral strobe, asynchronous, low means byte on offer |
| periphData | input | DATA_W | Peripheral data bus |
| hostAck | output | 1 | Host acknowledge, low means ready and high means accepting |
| outData | output | DATA_W | Published byte |
| outValid | output | 1 | Published byte is valid |
| outReady | input | 1 | Consumer can take a byte |
| timeoutErr | output | 1 | Sticky flag: the peripheral failed to release its strobe in time |

## Verification
The hardest situations to reach are the timeout abort and the hold-off with a full output register. Both depend on a peripheral that misbehaves or a consumer that stalls at just the right moment. The bench models the peripheral in tasks and, in one phase, strands the strobe low after the acknowledge. It then checks the abort, the block on a restart while the strobe is still low, and the recovery. In another phase it drops `outReady` so that a second byte is offered while the first still sits unconsumed. All 256 byte values are also transferred, with the bus inverted after the acknowledge on alternate bytes.

// File: rtl/rcvPkg.sv
package rcvPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HOLD,
    ST_WAITHI,
    ST_RECOVER
  } rcvStateT;

  typedef struct packed {
    logic captureEn;
    logic commitEn;
  } rcvStrobeT;
endpackage

// File: rtl/rcvDatapath.sv
module rcvDatapath
  import rcvPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphClkIn,
  input  logic [DATA_W-1:0] periphData,
  input  rcvStrobeT         strobe,
  input  logic              outReady,
  output logic              pclkSync,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [DATA_W-1:0]      holdQ;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], periphClkIn};
  end
  assign pclkSync = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdQ    <= '0;
      outData  <= '0;
      outValid <= 1'b0;
    end else begin
      if (strobe.captureEn) holdQ <= periphData;
      if (strobe.commitEn) begin
        outData  <= holdQ;
        outValid <= 1'b1;
      end else if (outValid && outReady) begin
        outValid <= 1'b0;
      end
    end
  end

  p_commit_empty_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitEn |-> !outValid);
  p_valid_holds_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outData)));
endmodule

// File: rtl/rcvCtrl.sv
module rcvCtrl
  import rcvPkg::*;
#(
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      pclkSync,
  input  logic      outValid,
  input  logic      outReady,
  output rcvStrobeT strobe,
  output logic      hostAck,
  output logic      timeoutErr
);
  localparam int CNT_W = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TIMEOUT_CYCLES - 1);

  rcvStateT        stateQ, stateD;
  logic [CNT_W-1:0] waitCnt;
  logic            expire;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    expire = 1'b0;
    unique case (stateQ)
      ST_IDLE: if (!pclkSync) begin
        strobe.captureEn = 1'b1;
        stateD = ST_HOLD;
      end
      ST_HOLD: if (!outValid && outReady) stateD = ST_WAITHI;
      ST_WAITHI: begin
        if (pclkSync) begin
          strobe.commitEn = 1'b1;
          stateD = ST_IDLE;
        end else if (waitCnt == CNT_LAST) begin
          expire = 1'b1;
          stateD = ST_RECOVER;
        end
      end
      ST_RECOVER: if (pclkSync) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      hostAck    <= 1'b0;
      waitCnt    <= '0;
      timeoutErr <= 1'b0;
    end else begin
      stateQ     <= stateD;
      hostAck    <= (stateD == ST_WAITHI);
      waitCnt    <= (stateQ == ST_WAITHI && stateD == ST_WAITHI) ? waitCnt + 1'b1 : '0;
      timeoutErr <= timeoutErr | expire;
    end
  end

  p_ack_room_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostAck) |-> $past(!outValid && outReady));
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |=> timeoutErr);
  p_ack_drop_timeout_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timeoutErr) |-> !hostAck);
endmodule

// File: rtl/ecpRevReceiver.sv
module ecpRevReceiver
  import rcvPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              periphClkIn,
  input  logic [DATA_W-1:0] periphData,
  output logic              hostAck,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outReady,
  output logic              timeoutErr
);
  rcvStrobeT strobe;
  logic      pclkSync;

  rcvDatapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_datapath (
    .clk(clk), .rstN(rstN), .periphClkIn(periphClkIn), .periphData(periphData),
    .strobe(strobe), .outReady(outReady), .pclkSync(pclkSync),
    .outValid(outValid), .outData(outData)
  );

  rcvCtrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .pclkSync(pclkSync), .outValid(outValid),
    .outReady(outReady), .strobe(strobe), .hostAck(hostAck), .timeoutErr(timeoutErr)
  );

  p_publish_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> $fell(hostAck));
endmodule

// File: tb/test_ecpRevReceiver.sv
module test_ecpRevReceiver;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       periphClk = 1'b1;
  logic [7:0] periphData = '0;
  logic       outReady = 1'b1;
  logic       hostAck, outValid, timeoutErr;
  logic [7:0] outData;
  int nChecks = 0;
  int nErr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecpRevReceiver #(.DATA_W(8), .SYNC_STAGES(2), .TIMEOUT_CYCLES(TMO)) i_ecpRevReceiver (
    .clk(clk), .rstN(rstN), .periphClkIn(periphClk), .periphData(periphData),
    .hostAck(hostAck), .outData(outData), .outValid(outValid),
    .outReady(outReady), .timeoutErr(timeoutErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitAck(output int n);
    n = 0;
    while (!hostAck && n < 100) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishByte(input logic [7:0] b);
    periphClk = 1'b1;
    cyc(2);
    chk(!outValid, "R5 early publish", int'(outValid), 0);
    cyc(1);
    chk(outValid && !hostAck, "R5 publish/ack", int'({outValid, hostAck}), 2);
    chk(outData == b, "R9 byte value", int'(outData), int'(b));
  endtask

  task automatic xfer(input logic [7:0] b, input bit scramble);
    int n;
    periphData = b;
    periphClk = 1'b0;
    waitAck(n);
    chk(n == 4, "R3 ack latency", n, 4);
    if (scramble) periphData = ~b;
    cyc(3);
    chk(hostAck && !outValid, "R5 ack held", int'({hostAck, outValid}), 2);
    finishByte(b);
    cyc(1);
    chk(!outValid, "R6 consumed", int'(outValid), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nErr++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    chk(!hostAck && !outValid && !timeoutErr, "R1 reset state",
        int'({hostAck, outValid, timeoutErr}), 0);
    rstN = 1'b1;
    cyc(20);
    chk(!hostAck && !outValid, "R2 idle", int'({hostAck, outValid}), 0);

    for (int b = 0; b < 256; b++) xfer(8'(b), b[0]);

    // R4 hold-off by outReady low
    outReady = 1'b0;
    periphData = 8'h3C;
    periphClk = 1'b0;
    cyc(15);
    chk(!hostAck, "R4 ready low", int'(hostAck), 0);
    outReady = 1'b1;
    waitAck(n);
    chk(hostAck == 1'b1, "R4 ack after ready", int'(hostAck), 1);
    outReady = 1'b0;
    finishByte(8'h3C);
    cyc(6);
    chk(outValid && outData == 8'h3C, "R6 hold stable", int'(outData), 8'h3C);
    // second byte offered while slot full
    periphData = 8'h5A;
    periphClk = 1'b0;
    cyc(15);
    chk(!hostAck, "R4 slot full", int'(hostAck), 0);
    chk(outValid && outData == 8'h3C, "R6 still held", int'(outData), 8'h3C);
    outReady = 1'b1;
    cyc(1);
    chk(!outValid, "R6 consume", int'(outValid), 0);
    waitAck(n);
    chk(hostAck == 1'b1, "R4 ack after drain", int'(hostAck), 1);
    finishByte(8'h5A);
    cyc(1);

    // R7 timeout
    periphData = 8'h77;
    periphClk = 1'b0;
    waitAck(n);
    chk(n == 4, "R3 ack latency", n, 4);
    cyc(TMO + 10);
    chk(timeoutErr && !hostAck && !outValid, "R7 timeout abort",
        int'({timeoutErr, hostAck, outValid}), 4);
    cyc(10);
    chk(!hostAck, "R8 no restart while low", int'(hostAck), 0);
    periphClk = 1'b1;
    cyc(10);
    chk(!hostAck && !outValid, "R8 aborted byte dropped", int'({hostAck, outValid}), 0);
    chk(timeoutErr, "R7 sticky", int'(timeoutErr), 1);
    xfer(8'h81, 1'b1);
    chk(timeoutErr, "R7 sticky after resume", int'(timeoutErr), 1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule